// File: doc/BRIEF.md
# Serial Peripheral Master with Slave Busy Gating

This block is a serial peripheral master that exchanges bytes with one coprocessor slave. The slave has no way to stall the serial clock, so it drives a separate busy line: while busy is high the master may send command bytes, while busy is low it may clock result bytes back in. Software-facing logic hands the block one byte at a time on a request port, marking whether the byte belongs to a write or a read and whether it closes the frame. Each byte waits until the synchronized busy level matches its direction, then chip select drops and eight serial clock periods move the byte out on MOSI while MISO is captured, most significant bit first.

Every byte is full duplex, so every byte that is actually clocked produces one received byte on the response port, flagged by a one-cycle valid pulse. Chip select stays low between bytes of one frame and returns high after the frame's last byte, with an enforced idle gap before the next frame. A byte that waits too long for the right busy level is dropped, chip select is released, and an error flag is raised. A synchronous reset returns the block to idle from any state, which is how a hung slave is recovered.

The clock polarity and phase are fixed by parameters (default: clock idles low, data sampled on the rising edge, data changed on the falling edge). The serial clock half period is a parameter counted in system clocks.

Top module: `spi_busy_master`

## Requirements
- R1: While `rst` is high at a rising clock edge, and from any state, the block returns to idle: after that edge `spi_cs_n`=1, `spi_sclk`=CPOL, `req_ready`=1, `rsp_valid`=0, `err_timeout`=0, and an interrupted byte yields no response.
- R2: A byte with `req_write`=1 starts only while the synchronized busy is 1, and a byte with `req_write`=0 only while it is 0; busy passes through a two-flop synchronizer, so while a byte waits, `spi_cs_n` falls on the third rising clock edge after `busy` takes the required level.
- R3: `req_data` is shifted out on `spi_mosi` most significant bit first, each bit stable at the sampling edge (rising edge in the default mode, with the first bit present when `spi_cs_n` falls and later bits changed on falling edges).
- R4: `spi_miso` is captured most significant bit first on the sampling edges of every byte, writes and reads alike; `rsp_data` holds the captured byte while `rsp_valid` is high, and `rsp_valid` is a single-cycle pulse, exactly one per clocked byte.
- R5: `spi_sclk` sits at CPOL whenever `spi_cs_n` is high; within a byte its period is 2*HALF_DIV system clocks, with eight sampling edges per byte.
- R6: `spi_cs_n` stays low from the first byte of a frame through the byte accepted with `req_last`=1, and rises once after that byte.
- R7: Between frames `spi_cs_n` stays high for at least 2*HALF_DIV system clocks.
- R8: If a waiting byte has not started when its wait counter equals `to_limit`, `err_timeout` rises on the (`to_limit`+1)th rising edge after the byte was accepted; the byte is dropped with no response, `spi_cs_n` returns high, and the flag clears when the next request is accepted.
- R9: `req_ready` is high only when idle or between bytes of an open frame, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high; it is low while a byte is being clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| to_limit | input | TO_W | Wait limit in clocks for a byte waiting on busy |
| req_valid | input | 1 | Request byte offered |
| req_ready | output | 1 | Block can take a request byte |
| req_data | input | BYTE_W | Byte to send |
| req_write | input | 1 | 1: write byte (needs busy high), 0: read byte (needs busy low) |
| req_last | input | 1 | Byte closes the frame |
| rsp_valid | output | 1 | One-cycle pulse per received byte |
| rsp_data | output | BYTE_W | Received byte |
| err_timeout | output | 1 | A byte was dropped after waiting too long |
| busy | input | 1 | Slave flow-control line, asynchronous |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |

## Verification
The start of a byte is due on the third rising edge after busy reaches the needed level, and the timeout flag on the (`to_limit`+1)th edge after acceptance; the bench counts those edges from the moment it changes busy or sees its request taken and samples on the falling edge just before and just after the due edge. Response bytes appear half a serial clock period after the last serial edge, so the bench waits on its own count of valid pulses rather than a fixed delay and then compares the byte with the value its slave model drove. Clock period, idle level, chip-select gap and pulse width are measured continuously by a falling-edge monitor and reported at the end.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_GAP   = 3'd3,
    ST_GUARD = 3'd4
  } bm_state_t;

endpackage

// File: rtl/spi_bm_sync.sv
module spi_bm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];

endmodule

// File: rtl/spi_bm_edgegen.sv
module spi_bm_edgegen #(
  parameter int HALF_DIV = 2,
  parameter int BITS     = 8,
  parameter bit CPOL     = 1'b0,
  parameter bit CPHA     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic launch,
  output logic sample,
  output logic done
);

  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int HW    = $clog2(HALF_DIV + 1);

  logic [HW-1:0] hp;
  logic [EW-1:0] eidx;
  logic          lvl;
  logic          tick;
  logic          in_byte;

  assign tick    = run && (hp == HW'(HALF_DIV - 1));
  assign in_byte = eidx < EW'(EDGES);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hp   <= '0;
      eidx <= '0;
      lvl  <= 1'b0;
    end else if (tick) begin
      hp <= '0;
      if (in_byte) begin
        lvl  <= ~lvl;
        eidx <= eidx + 1'b1;
      end else begin
        eidx <= '0;
      end
    end else begin
      hp <= hp + 1'b1;
    end
  end

  generate
    if (CPHA == 1'b0) begin : g_pha0
      assign sample = tick && in_byte && !eidx[0];
      assign launch = tick && in_byte && eidx[0] && (eidx != EW'(EDGES - 1));
    end else begin : g_pha1
      assign sample = tick && in_byte && eidx[0];
      assign launch = tick && in_byte && !eidx[0] && (eidx != '0);
    end
  endgenerate

  assign done = tick && !in_byte;
  assign sclk = lvl ^ CPOL;

endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            launch,
  input  logic            sample,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rx_data
);

  logic [BITS-1:0] tx_sr;
  logic [BITS-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load)        tx_sr <= load_data;
      else if (launch) tx_sr <= {tx_sr[BITS-2:0], 1'b0};
      if (sample)      rx_sr <= {rx_sr[BITS-2:0], miso};
    end
  end

  assign mosi    = tx_sr[BITS-1];
  assign rx_data = rx_sr;

endmodule

// File: rtl/spi_busy_master.sv
module spi_busy_master
  import spi_bm_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int BYTE_W      = 8,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit CPOL        = 1'b0,
  parameter bit CPHA        = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TO_W-1:0]   to_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BYTE_W-1:0] req_data,
  input  logic              req_write,
  input  logic              req_last,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              err_timeout,
  input  logic              busy,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int GUARD_CYC = 2 * HALF_DIV;
  localparam int GW        = $clog2(GUARD_CYC + 1);

  bm_state_t         state;
  logic              busy_s;
  logic              wr_q;
  logic              last_q;
  logic [TO_W-1:0]   wait_cnt;
  logic [GW-1:0]     guard_cnt;
  logic              run;
  logic              launch;
  logic              sample;
  logic              done;
  logic              accept;
  logic              go;
  logic [BYTE_W-1:0] rx_byte;

  assign req_ready = (state == ST_IDLE) || (state == ST_GAP);
  assign accept    = req_valid && req_ready;
  assign go        = wr_q ? busy_s : !busy_s;
  assign run       = (state == ST_SHIFT);

  spi_bm_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (busy),
    .q   (busy_s)
  );

  spi_bm_edgegen #(
    .HALF_DIV(HALF_DIV),
    .BITS    (BYTE_W),
    .CPOL    (CPOL),
    .CPHA    (CPHA)
  ) u_edge (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .sclk   (spi_sclk),
    .launch (launch),
    .sample (sample),
    .done   (done)
  );

  spi_bm_shifter #(
    .BITS(BYTE_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (req_data),
    .launch    (launch),
    .sample    (sample),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_data   (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      spi_cs_n    <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      err_timeout <= 1'b0;
      wr_q        <= 1'b0;
      last_q      <= 1'b0;
      wait_cnt    <= '0;
      guard_cnt   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE, ST_GAP: begin
          if (accept) begin
            wr_q        <= req_write;
            last_q      <= req_last;
            wait_cnt    <= '0;
            err_timeout <= 1'b0;
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (go) begin
            spi_cs_n <= 1'b0;
            state    <= ST_SHIFT;
          end else if (wait_cnt == to_limit) begin
            err_timeout <= 1'b1;
            spi_cs_n    <= 1'b1;
            guard_cnt   <= '0;
            state       <= ST_GUARD;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (done) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rx_byte;
            if (last_q) begin
              spi_cs_n  <= 1'b1;
              guard_cnt <= '0;
              state     <= ST_GUARD;
            end else begin
              state <= ST_GAP;
            end
          end
        end
        ST_GUARD: begin
          if (guard_cnt == GW'(GUARD_CYC - 1)) state <= ST_IDLE;
          else                                 guard_cnt <= guard_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker #(
  parameter bit CPOL = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic req_ready,
  input logic rsp_valid,
  input logic err,
  input logic busy_s,
  input logic wr_q
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n && !rsp_valid && req_ready && !err)); // R1

  AST_DIR_GATE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(wr_q ? busy_s : !busy_s)); // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R4

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (sclk == CPOL)); // R5

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && (sclk != CPOL)) |=> !cs_n); // R6

  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> cs_n); // R8

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && (sclk != CPOL)) |-> !req_ready); // R9

endmodule

bind spi_busy_master spi_bm_checker #(
  .CPOL(CPOL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (spi_cs_n),
  .sclk      (spi_sclk),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .err       (err_timeout),
  .busy_s    (busy_s),
  .wr_q      (wr_q)
);

// File: tb/spi_busy_master_tb.sv
`timescale 1ns/1ps
module spi_busy_master_tb;

  localparam int HALF_DIV = 2;
  localparam int BW       = 8;
  localparam int TO_W     = 16;
  localparam bit CPOL     = 1'b0;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [TO_W-1:0] to_limit = 16'd1000;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [BW-1:0]   req_data = '0;
  logic            req_write = 1'b0;
  logic            req_last = 1'b0;
  logic            rsp_valid;
  logic [BW-1:0]   rsp_data;
  logic            err_timeout;
  logic            busy = 1'b0;
  logic            spi_cs_n;
  logic            spi_sclk;
  logic            spi_mosi;
  logic            spi_miso = 1'b0;

  spi_busy_master #(
    .HALF_DIV(HALF_DIV), .BYTE_W(BW), .TO_W(TO_W), .SYNC_STAGES(2),
    .CPOL(CPOL), .CPHA(1'b0)
  ) u_dut (
    .clk(clk), .rst(rst), .to_limit(to_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_write(req_write), .req_last(req_last),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_timeout(err_timeout),
    .busy(busy), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model and monitors, all on the falling edge
  logic [7:0] slv_seed = 8'h00;
  logic [7:0] s_tx = 8'h00;
  logic [7:0] s_rx = 8'h00;
  logic [7:0] slv_log [4];
  logic [7:0] rsp_log [4];
  int s_bits = 0, s_nb = 0, slv_cnt = 0, rsp_cnt = 0, cs_rise = 0;
  int cyc = 0, last_rise = 0, hi_run = 1000;
  int idle_bad = 0, per_bad = 0, per_n = 0, gap_bad = 0, pulse_bad = 0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_rv = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (spi_cs_n && spi_sclk !== CPOL) idle_bad++;
      if (spi_cs_n && !p_cs) cs_rise++;
      if (spi_cs_n) hi_run++;
      if (!spi_cs_n && p_cs) begin
        if (hi_run < 2*HALF_DIV) gap_bad++;
        hi_run = 0;
        s_bits = 0;
        s_nb = 0;
        s_tx = slv_seed;
        spi_miso = s_tx[7];
      end else if (!spi_cs_n) begin
        if (spi_sclk && !p_sclk) begin
          if (s_bits % 8 != 0) begin
            per_n++;
            if (cyc - last_rise != 2*HALF_DIV) per_bad++;
          end
          last_rise = cyc;
          s_rx = {s_rx[6:0], spi_mosi};
          s_bits++;
          if (s_bits % 8 == 0) begin
            slv_log[slv_cnt % 4] = s_rx;
            slv_cnt++;
          end
        end
        if (!spi_sclk && p_sclk) begin
          if (s_bits % 8 == 0) begin
            s_nb++;
            s_tx = slv_seed + 8'(s_nb);
          end else begin
            s_tx = {s_tx[6:0], 1'b0};
          end
          spi_miso = s_tx[7];
        end
      end
      if (rsp_valid) begin
        rsp_log[rsp_cnt % 4] = rsp_data;
        rsp_cnt++;
        if (p_rv) pulse_bad++;
      end
    end
    p_cs = spi_cs_n;
    p_sclk = spi_sclk;
    p_rv = rsp_valid;
  end

  task automatic push(input logic [7:0] d, input logic wr, input logic lst);
    @(negedge clk);
    req_valid = 1'b1; req_data = d; req_write = wr; req_last = lst;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int target);
    while (rsp_cnt < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(req_ready && spi_cs_n)) @(negedge clk);
  endtask

  task automatic frame1(input logic [7:0] d, input logic wr);
    int b0, s0;
    b0 = rsp_cnt; s0 = slv_cnt;
    slv_seed = d ^ 8'h5A;
    push(d, wr, 1'b1);
    wait_rsp(b0 + 1);
    wait_idle();
    check(slv_cnt == s0 + 1 && slv_log[s0 % 4] == d, "R3 mosi byte", int'(slv_log[s0 % 4]), int'(d));
    check(rsp_log[b0 % 4] == (d ^ 8'h5A), "R4 miso byte", int'(rsp_log[b0 % 4]), int'(d ^ 8'h5A));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0, s0, c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(spi_cs_n == 1'b1, "R1 reset cs_n", int'(spi_cs_n), 1);
    check(spi_sclk == CPOL, "R1 reset sclk", int'(spi_sclk), int'(CPOL));
    check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0 && err_timeout == 1'b0, "R1 reset flags", int'({rsp_valid, err_timeout}), 0);

    // write sweep, busy high
    busy = 1'b1;
    repeat (4) @(negedge clk);
    for (int d = 0; d < 256; d++) frame1(8'(d), 1'b1);

    // read sweep, busy low
    busy = 1'b0;
    repeat (4) @(negedge clk);
    for (int d = 0; d < 256; d++) frame1(8'(255 - d), 1'b0);

    // R2 write gated by busy low
    to_limit = 16'd200;
    slv_seed = 8'h3C;
    b0 = rsp_cnt; s0 = slv_cnt;
    push(8'h44, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check(spi_cs_n == 1'b1, "R2 write held while busy low", int'(spi_cs_n), 1);
    busy = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(spi_cs_n == 1'b1, "R2 cs before third edge", int'(spi_cs_n), 1);
    @(posedge clk); @(negedge clk);
    check(spi_cs_n == 1'b0, "R2 cs on third edge", int'(spi_cs_n), 0);
    repeat (2*HALF_DIV + 1) @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low while clocking", int'(req_ready), 0);
    wait_rsp(b0 + 1);
    wait_idle();
    check(slv_log[s0 % 4] == 8'h44, "R2 gated write byte", int'(slv_log[s0 % 4]), 'h44);

    // R2 read gated by busy high
    slv_seed = 8'hE7;
    b0 = rsp_cnt;
    push(8'h00, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(spi_cs_n == 1'b1, "R2 read held while busy high", int'(spi_cs_n), 1);
    busy = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(spi_cs_n == 1'b1, "R2 read cs before third edge", int'(spi_cs_n), 1);
    @(posedge clk); @(negedge clk);
    check(spi_cs_n == 1'b0, "R2 read cs on third edge", int'(spi_cs_n), 0);
    wait_rsp(b0 + 1);
    wait_idle();
    check(rsp_log[b0 % 4] == 8'hE7, "R4 gated read byte", int'(rsp_log[b0 % 4]), 'hE7);

    // R8 timeout from idle: write while busy low
    to_limit = 16'd5;
    b0 = rsp_cnt; s0 = slv_cnt; c0 = cs_rise;
    push(8'h33, 1'b1, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(err_timeout == 1'b0, "R8 err before limit", int'(err_timeout), 0);
    @(posedge clk); @(negedge clk);
    check(err_timeout == 1'b1, "R8 err at limit+1", int'(err_timeout), 1);
    wait_idle();
    repeat (10) @(negedge clk);
    check(rsp_cnt == b0 && slv_cnt == s0 && cs_rise == c0, "R8 byte dropped", rsp_cnt - b0, 0);

    // R8 flag cleared by next accepted request
    busy = 1'b1;
    to_limit = 16'd200;
    repeat (4) @(negedge clk);
    b0 = rsp_cnt;
    slv_seed = 8'h77;
    push(8'hA1, 1'b1, 1'b1);
    @(negedge clk);
    check(err_timeout == 1'b0, "R8 err cleared on accept", int'(err_timeout), 0);
    wait_rsp(b0 + 1);
    wait_idle();

    // R6 multi-byte frame
    slv_seed = 8'hC0;
    b0 = rsp_cnt; s0 = slv_cnt; c0 = cs_rise;
    push(8'h11, 1'b1, 1'b0);
    push(8'h22, 1'b1, 1'b0);
    check(spi_cs_n == 1'b0, "R6 cs low between bytes", int'(spi_cs_n), 0);
    push(8'h33, 1'b1, 1'b1);
    wait_rsp(b0 + 3);
    wait_idle();
    check(cs_rise == c0 + 1, "R6 single cs rise per frame", cs_rise - c0, 1);
    check(slv_log[s0 % 4] == 8'h11 && slv_log[(s0+1) % 4] == 8'h22 && slv_log[(s0+2) % 4] == 8'h33,
          "R3 frame bytes", int'(slv_log[(s0+2) % 4]), 'h33);
    check(rsp_log[b0 % 4] == 8'hC0 && rsp_log[(b0+1) % 4] == 8'hC1 && rsp_log[(b0+2) % 4] == 8'hC2,
          "R4 frame responses", int'(rsp_log[(b0+2) % 4]), 'hC2);

    // R8 timeout inside an open frame releases cs
    slv_seed = 8'h10;
    b0 = rsp_cnt; s0 = slv_cnt;
    push(8'h81, 1'b1, 1'b0);
    wait_rsp(b0 + 1);
    @(negedge clk);
    check(req_ready == 1'b1 && spi_cs_n == 1'b0, "R9 ready between bytes", int'({req_ready, spi_cs_n}), 2);
    busy = 1'b0;
    to_limit = 16'd5;
    repeat (4) @(negedge clk);
    push(8'h82, 1'b1, 1'b1);
    repeat (12) @(negedge clk);
    check(spi_cs_n == 1'b1 && err_timeout == 1'b1, "R8 frame timeout", int'({spi_cs_n, err_timeout}), 3);
    check(slv_cnt == s0 + 1 && rsp_cnt == b0 + 1, "R8 frame byte dropped", slv_cnt - s0, 1);
    wait_idle();

    // R1 reset in the middle of a byte
    to_limit = 16'd200;
    b0 = rsp_cnt;
    push(8'h99, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check(spi_cs_n == 1'b0, "R1 transfer running", int'(spi_cs_n), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(spi_cs_n == 1'b1 && spi_sclk == CPOL && req_ready == 1'b1 && err_timeout == 1'b0,
          "R1 mid-transfer reset", int'({spi_cs_n, spi_sclk, req_ready, err_timeout}), 10);
    repeat (60) @(negedge clk);
    check(rsp_cnt == b0, "R1 no response after reset", rsp_cnt - b0, 0);

    // monitor results
    check(idle_bad == 0, "R5 sclk idle level", idle_bad, 0);
    check(per_bad == 0 && per_n > 0, "R5 sclk period", per_bad, 0);
    check(gap_bad == 0, "R7 cs high gap", gap_bad, 0);
    check(pulse_bad == 0, "R4 rsp pulse width", pulse_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule